// File: doc/BRIEF.md
# Bus Master Request Controller

This block runs the master side of one request/reply exchange on a shared half-duplex serial bus that has a single master and up to fifteen addressed slaves. The host presents a 4-bit destination ID, a command byte, a data count (LEN) and up to fifteen data bytes, and pulses `req_valid`. The controller then keeps the line quiet for a fixed synchronization gap. It counts this gap in microsecond ticks supplied from outside.

After the gap the controller streams the packet to an external byte transmitter through a valid/ready handshake. The packet is a header byte, the command, the data bytes and a checksum byte that the controller computes itself. It then waits for the transmitter's stop-bit completion of the final byte and opens a reply window. An external reply parser signals a received packet and reports its destination ID. A reply addressed to the master (ID 0) inside the window ends the exchange with `reply_ok`. If the window runs out, the exchange ends with `timeout`.

The gap and window lengths are parameters, 8500 us and 1000 us by default.

Top module: `bus_req_master`

## Requirements
- R1: After reset `busy`, `tx_valid`, `reply_ok` and `timeout` are all low.
- R2: A `req_valid` pulse while idle is taken on that clock edge, and `busy` is high from the next cycle until the exchange ends. A `req_valid` while `busy` is high has no effect on the bytes sent.
- R3: `tx_valid` stays low after acceptance until exactly GAP_US ticks of `us_tick` have been counted. It goes high in the cycle after the edge that counts the last of these ticks.
- R4: The first byte sent is the destination ID in bits 7-4 with LEN in bits 3-0. The second byte is the command.
- R5: Next come LEN data bytes in order. Data byte k is taken from `req_data[8k+7:8k]`. With LEN = 0 no data byte is sent.
- R6: Exactly LEN+3 bytes are sent. The last byte is the two's complement of the 8-bit sum of all earlier bytes, so all bytes of the packet sum to zero modulo 256.
- R7: From the first byte until the last byte is accepted, `tx_valid` stays high without a gap. While `tx_ready` is low, `tx_byte` holds its value.
- R8: The window opens at the `tx_done` pulse of the final byte. An `rx_reply_valid` with `rx_reply_dest` = 0 inside the window gives a one-cycle `reply_ok` on the next cycle, and in that same cycle `busy` is low.
- R9: A reply whose destination is not 0 is ignored: no `reply_ok` follows and the window keeps running.
- R10: With no accepted reply, `timeout` pulses for one cycle in the cycle after the WINDOW_US-th tick counted inside the window, and `busy` is low in that same cycle.
- R11: `reply_ok` and `timeout` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| req_valid | input | 1 | Request start strobe |
| req_dest | input | 4 | Destination slave ID |
| req_len | input | 4 | Number of data bytes, 0 to 15 |
| req_cmd | input | 8 | Command byte |
| req_data | input | 120 | Data bytes, byte k in bits 8k+7:8k |
| busy | output | 1 | Exchange in progress |
| tx_valid | output | 1 | Byte offered to transmitter |
| tx_byte | output | 8 | Byte offered to transmitter |
| tx_ready | input | 1 | Transmitter accepts byte |
| tx_done | input | 1 | Pulse when a byte's stop bit has completed |
| rx_reply_valid | input | 1 | Reply packet received pulse |
| rx_reply_dest | input | 4 | Destination ID of received reply |
| reply_ok | output | 1 | Reply to master received in window |
| timeout | output | 1 | Window expired without reply |

## Verification
The assertions rely on a few properties of the inputs. `us_tick`, `tx_done` and `rx_reply_valid` are single-cycle pulses. The transmitter raises `tx_done` exactly once per accepted byte, and never before that byte is accepted. Replies are only presented after the window has opened. The stimulus honours all of this by design. The transmitter model accepts a byte and then stalls `tx_ready` for a random 1 to 4 cycles, and it pulses `tx_done` when the stall ends. The tick is a free-running divider, and the bench injects replies only after the final `tx_done`, with a delay much shorter than the window.

// File: rtl/bus_req_master.sv
module bus_req_master #(
  parameter int GAP_US    = 8500,
  parameter int WINDOW_US = 1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         us_tick,
  input  logic         req_valid,
  input  logic [3:0]   req_dest,
  input  logic [3:0]   req_len,
  input  logic [7:0]   req_cmd,
  input  logic [119:0] req_data,
  output logic         busy,
  output logic         tx_valid,
  output logic [7:0]   tx_byte,
  input  logic         tx_ready,
  input  logic         tx_done,
  input  logic         rx_reply_valid,
  input  logic [3:0]   rx_reply_dest,
  output logic         reply_ok,
  output logic         timeout
);
  localparam int LEN_W  = 4;
  localparam int DATA_W = 8 * ((1 << LEN_W) - 1);
  localparam int LIM    = (GAP_US > WINDOW_US) ? GAP_US : WINDOW_US;
  localparam int CNT_W  = $clog2(LIM + 1);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_SEND, S_DRAIN, S_WAIT} st_t;

  st_t                st;
  logic [3:0]         dest_q;
  logic [LEN_W-1:0]   len_q;
  logic [7:0]         cmd_q;
  logic [DATA_W+7:0]  data_q;
  logic [LEN_W:0]     idx;
  logic [LEN_W:0]     dcnt;
  logic [CNT_W-1:0]   cnt;
  logic [7:0]         sum;

  wire [LEN_W:0]   last_idx  = {1'b0, len_q} + (LEN_W+1)'(2);
  wire [LEN_W:0]   dsub      = idx - (LEN_W+1)'(2);
  wire [LEN_W-1:0] didx      = dsub[LEN_W-1:0];
  wire             hs        = tx_valid & tx_ready;
  wire             reply_hit = rx_reply_valid && (rx_reply_dest == 4'd0);
  wire             gap_end   = (cnt == CNT_W'(GAP_US - 1));
  wire             win_end   = (cnt == CNT_W'(WINDOW_US - 1));

  assign busy     = (st != S_IDLE);
  assign tx_valid = (st == S_SEND);

  always_comb begin
    if (idx == '0)
      tx_byte = {dest_q, len_q};
    else if (idx == (LEN_W+1)'(1))
      tx_byte = cmd_q;
    else if (idx == last_idx)
      tx_byte = 8'd0 - sum;
    else
      tx_byte = data_q[{didx, 3'b000} +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      dest_q   <= '0;
      len_q    <= '0;
      cmd_q    <= '0;
      data_q   <= '0;
      idx      <= '0;
      dcnt     <= '0;
      cnt      <= '0;
      sum      <= '0;
      reply_ok <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      reply_ok <= 1'b0;
      timeout  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          dest_q <= req_dest;
          len_q  <= req_len;
          cmd_q  <= req_cmd;
          data_q <= {8'h00, req_data};
          idx    <= '0;
          dcnt   <= '0;
          cnt    <= '0;
          sum    <= '0;
          st     <= S_GAP;
        end
        S_GAP: if (us_tick) begin
          if (gap_end) begin
            cnt <= '0;
            st  <= S_SEND;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SEND: begin
          if (tx_done) dcnt <= dcnt + 1'b1;
          if (hs) begin
            if (idx == last_idx) begin
              st <= S_DRAIN;
            end else begin
              idx <= idx + 1'b1;
              sum <= sum + tx_byte;
            end
          end
        end
        S_DRAIN: if (tx_done) begin
          if (dcnt == last_idx) begin
            cnt <= '0;
            st  <= S_WAIT;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (reply_hit) begin
            reply_ok <= 1'b1;
            st       <= S_IDLE;
          end else if (us_tick) begin
            if (win_end) begin
              timeout <= 1'b1;
              st      <= S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module bus_req_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       us_tick,
  input logic       busy,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte,
  input logic       rx_reply_valid,
  input logic [3:0] rx_reply_dest,
  input logic       reply_ok,
  input logic       timeout
);
  a_r7_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

  a_r2_busy_covers_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);

  a_r3_first_byte_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(us_tick));

  a_r8_ok_needs_master_id: assert property (@(posedge clk) disable iff (!rst_n)
    reply_ok |-> $past(rx_reply_valid) && ($past(rx_reply_dest) == 4'd0));

  a_r8_ok_releases: assert property (@(posedge clk) disable iff (!rst_n)
    reply_ok |-> !busy);

  a_r10_timeout_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(us_tick) && $past(busy) && !busy);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reply_ok && timeout));
endmodule

bind bus_req_master bus_req_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .busy(busy),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
  .rx_reply_valid(rx_reply_valid), .rx_reply_dest(rx_reply_dest),
  .reply_ok(reply_ok), .timeout(timeout)
);

// File: tb/bus_req_master_tb.sv
`timescale 1ns/1ps
module bus_req_master_tb_top;
  localparam int GAP  = 25;
  localparam int WIN  = 40;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         us_tick = 1'b0;
  logic         req_valid = 1'b0;
  logic [3:0]   req_dest = '0;
  logic [3:0]   req_len = '0;
  logic [7:0]   req_cmd = '0;
  logic [119:0] req_data = '0;
  logic         busy, tx_valid, reply_ok, timeout;
  logic [7:0]   tx_byte;
  logic         tx_ready = 1'b1;
  logic         tx_done = 1'b0;
  logic         rx_reply_valid = 1'b0;
  logic [3:0]   rx_reply_dest = '0;

  bus_req_master #(.GAP_US(GAP), .WINDOW_US(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .req_valid(req_valid), .req_dest(req_dest), .req_len(req_len),
    .req_cmd(req_cmd), .req_data(req_data), .busy(busy),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .tx_done(tx_done), .rx_reply_valid(rx_reply_valid),
    .rx_reply_dest(rx_reply_dest), .reply_ok(reply_ok), .timeout(timeout)
  );

  int nchk = 0, nerr = 0;
  logic [7:0] cap [0:31];
  int ncap = 0, done_cnt = 0, total = 0;
  bit gap_on = 0, sending = 0, win_on = 0, to_seen = 0, ok_seen = 0;
  int gap_ticks = 0, wticks = 0;
  bit prev_v = 0, prev_r = 0;
  logic [7:0] prev_b = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [3:0] d, input logic [3:0] l,
                                          input logic [7:0] c, input logic [119:0] dat, input int i);
    logic [7:0] s;
    if (i == 0) return {d, l};
    if (i == 1) return c;
    if (i < int'(l) + 2) return dat[8*(i-2) +: 8];
    s = {d, l} + c;
    for (int k = 0; k < int'(l); k++) s = s + dat[8*k +: 8];
    return 8'd0 - s;
  endfunction

  initial begin
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      us_tick = 1'b1;
      @(negedge clk);
      us_tick = 1'b0;
    end
  end

  initial begin
    bit pend;
    int hold;
    pend = 0; hold = 0;
    forever begin
      @(negedge clk);
      tx_done = 1'b0;
      if (pend) begin
        pend = 0;
        tx_ready = 1'b0;
        hold = $urandom_range(1, 4);
      end else if (hold > 0) begin
        hold--;
        if (hold == 0) begin
          tx_done = 1'b1;
          tx_ready = 1'b1;
          done_cnt++;
        end
      end
      if (tx_ready && tx_valid) begin
        cap[ncap[4:0]] = tx_byte;
        ncap++;
        pend = 1;
      end
    end
  end

  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (reply_ok && timeout) check(0, "R11", 1, 0);
      if (timeout) begin
        to_seen = 1;
        check(win_on && wticks == WIN, "R10", wticks, WIN);
        win_on = 0;
      end
      if (reply_ok) begin
        ok_seen = 1;
        win_on = 0;
      end
      if (win_on && us_tick) wticks++;
      if (sending && tx_done && done_cnt == total && ncap == total && !win_on) begin
        win_on = 1;
        wticks = 0;
        sending = 0;
      end
      if (sending && ncap < total) check(tx_valid, "R7", tx_valid, 1);
      if (prev_v && !prev_r) check(tx_valid && tx_byte == prev_b, "R7", tx_byte, prev_b);
      if (req_valid && !busy) begin
        gap_on = 1;
        gap_ticks = 0;
      end else if (gap_on) begin
        if (tx_valid) begin
          check(gap_ticks == GAP, "R3", gap_ticks, GAP);
          gap_on = 0;
          sending = 1;
        end else if (us_tick) begin
          gap_ticks++;
        end
      end
      prev_v = tx_valid;
      prev_r = tx_ready;
      prev_b = tx_byte;
    end
  end

  task automatic run_txn(input logic [3:0] d, input logic [7:0] c, input logic [3:0] l,
                         input logic [119:0] dat, input int mode);
    int guard;
    int s;
    @(negedge clk);
    ncap = 0; done_cnt = 0; total = int'(l) + 3;
    to_seen = 0; ok_seen = 0;
    req_dest = d; req_cmd = c; req_len = l; req_data = dat; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #2 check(busy, "R2", busy, 1);
    @(negedge clk);
    req_dest = ~d; req_cmd = ~c; req_len = ~l; req_data = ~dat; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (done_cnt < total && guard < 5000) begin @(negedge clk); guard++; end
    @(negedge clk);
    #2;
    check(ncap == total, "R6", ncap, total);
    check(cap[0] == exp_byte(d, l, c, dat, 0), "R4", cap[0], exp_byte(d, l, c, dat, 0));
    check(cap[0] == {d, l}, "R2", cap[0], {d, l});
    check(cap[1] == c, "R4", cap[1], c);
    for (int i = 2; i < total - 1; i++)
      check(cap[i] == exp_byte(d, l, c, dat, i), "R5", cap[i], exp_byte(d, l, c, dat, i));
    s = 0;
    for (int i = 0; i < total; i++) s += cap[i];
    check(s[7:0] == 8'd0, "R6", s[7:0], 0);
    check(cap[total-1] == exp_byte(d, l, c, dat, total - 1), "R6", cap[total-1],
          exp_byte(d, l, c, dat, total - 1));
    if (mode == 0) begin
      repeat ($urandom_range(1, WIN / 2)) @(negedge clk);
      rx_reply_valid = 1'b1; rx_reply_dest = 4'd0;
      @(negedge clk);
      rx_reply_valid = 1'b0;
      #2 check(reply_ok && !timeout && !busy, "R8", reply_ok, 1);
      @(negedge clk);
      #2 check(!reply_ok && !busy, "R8", reply_ok, 0);
    end else begin
      if (mode == 1) begin
        repeat ($urandom_range(1, WIN / 2)) @(negedge clk);
        rx_reply_valid = 1'b1; rx_reply_dest = 4'($urandom_range(1, 15));
        @(negedge clk);
        rx_reply_valid = 1'b0;
        #2 check(!reply_ok && busy, "R9", reply_ok, 0);
      end
      guard = 0;
      while (busy && guard < 5000) begin @(negedge clk); #2; guard++; end
      check(to_seen && !ok_seen, "R10", to_seen, 1);
      if (mode == 1) check(!ok_seen, "R9", ok_seen, 0);
    end
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    logic [119:0] dat;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    #2 check(!busy && !tx_valid && !reply_ok && !timeout, "R1", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_txn(4'h1, 8'h5e, 4'd0, '0, 0);
    run_txn(4'hf, 8'hff, 4'd15, {120{1'b1}}, 2);
    run_txn(4'h7, 8'h5f, 4'd1, 120'hA5, 1);
    for (int n = 0; n < 30; n++) begin
      for (int k = 0; k < 15; k++) dat[8*k +: 8] = 8'($urandom);
      run_txn(4'($urandom_range(1, 15)), 8'($urandom), 4'($urandom_range(0, 15)), dat,
              $urandom_range(0, 2));
    end
    report();
  end
endmodule